// File: doc/BRIEF.md
# Frame Base Shadow with Update Interrupt

This block sits on the register side of a display controller. It holds the frame buffer start address that software programs and a second, active copy that the scan-out engine reads from. Software may write the pending address at any time. The active copy is loaded from it only when the timing generator pulses its frame-start strobe, so a frame is never fetched from two buffers and page flips do not tear.

When a pending address that software wrote is moved into the active copy, the block raises an "address taken" interrupt cause. Software flips a page by writing a new address and then waiting for that interrupt. After the interrupt it knows the old buffer is free. The cause is gated by an enable register into a masked status register and a single interrupt line. Software acknowledges the cause through a write-one-to-clear register.

The register port is a simple single-cycle write strobe with a word address. Read data is combinational from the addressed register. Register word addresses: 0 holds the pending base, 1 the interrupt enable, 2 the raw status, 3 the masked status, and 4 the clear register. The clear register is write-only and reads as zero. The update cause lives in bit 0 of the enable, raw, masked and clear registers. All other bits of those registers read as zero.

Top module: `fbs_top`

## Requirements
- R1: After reset the active base, the pending base, the enable, the raw status and the masked status are all zero, and irq_o is low.
- R2: A write to address 0 stores the written value with bits [1:0] forced to zero. A read of address 0 returns the stored value, and active_base_o never has bits [1:0] set.
- R3: active_base_o changes only in the cycle after frame_start_i is high. A base write made mid-frame is not visible on active_base_o until the next strobe.
- R4: Raw status bit 0 is set by a frame-start strobe only if address 0 has been written since the previous strobe. A strobe with no new write sets nothing.
- R5: When a base write and a frame-start strobe occur in the same cycle, the strobe loads the previously pending value. The new value stays pending and is loaded, with its own status event, at the following strobe.
- R6: The masked status (address 3) equals the raw status AND the enable (address 1, bit 0). irq_o is the OR of the masked bits. Writing zero to address 1 drops irq_o in the next cycle.
- R7: A write to address 4 clears each raw status bit that is 1 in the written value. Bits that are 0 in the written value are left unchanged.
- R8: If a clear of bit 0 and a status set by a frame-start strobe happen in the same cycle, the bit ends up set.
- R9: Writes to addresses 2 and 3 change nothing. Reads of address 4 and of addresses 5 to 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the addressed register |
| frame_start_i | input | 1 | One-cycle pulse at the start of each frame |
| active_base_o | output | 32 | Base address in use by scan-out |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench aims at the same-cycle collisions. A base write together with the strobe must load the old address and keep the new one pending; a design that loads the new value early, or loses it, shows a wrong active base or a missing second event. A clear together with a set must leave the bit set; a design that lets the clear win loses a flip acknowledgement. Strobes with no fresh write must raise nothing; a design that sets status on every frame would wake software each vertical period. Unaligned writes, writes to the read-only status words and reads of unmapped words are driven to catch any stray decode.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_BASE = 3'd0,
    REG_IEN  = 3'd1,
    REG_RAW  = 3'd2,
    REG_MIS  = 3'd3,
    REG_CLR  = 3'd4
  } fbs_reg_e;

  // bit index of the "base taken" cause
  localparam int unsigned UPD_BIT = 0;
endpackage

// File: rtl/fbs_reg_dec.sv
module fbs_reg_dec
  import fbs_pkg::*;
(
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  output logic              base_we_o,
  output logic              ien_we_o,
  output logic              clr_we_o
);
  always_comb begin
    base_we_o = 1'b0;
    ien_we_o  = 1'b0;
    clr_we_o  = 1'b0;
    if (we_i) begin
      unique case (addr_i)
        REG_BASE: base_we_o = 1'b1;
        REG_IEN:  ien_we_o  = 1'b1;
        REG_CLR:  clr_we_o  = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/fbs_base_shadow.sv
module fbs_base_shadow #(
  parameter int unsigned BASE_W     = 32,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BASE_W-1:0] wdata_i,
  input  logic              frame_start_i,
  output logic [BASE_W-1:0] pend_base_o,
  output logic [BASE_W-1:0] act_base_o,
  output logic              taken_o
);
  localparam logic [BASE_W-1:0] ALIGN_MASK = BASE_W'((1 << ALIGN_BITS) - 1);

  logic [BASE_W-1:0] pend_q, act_q;
  logic              fresh_q;

  // strobe always loads the value pending before this edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      act_q   <= '0;
      fresh_q <= 1'b0;
    end else begin
      if (wr_i)          pend_q <= wdata_i & ~ALIGN_MASK;
      if (frame_start_i) act_q  <= pend_q;
      if (wr_i)               fresh_q <= 1'b1;
      else if (frame_start_i) fresh_q <= 1'b0;
    end
  end

  assign taken_o     = frame_start_i & fresh_q;
  assign pend_base_o = pend_q;
  assign act_base_o  = act_q;
endmodule

// File: rtl/fbs_irq_ctrl.sv
module fbs_irq_ctrl #(
  parameter int unsigned NUM_CAUSES = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_CAUSES-1:0] set_i,
  input  logic                  ien_we_i,
  input  logic                  clr_we_i,
  input  logic [NUM_CAUSES-1:0] wdata_i,
  output logic [NUM_CAUSES-1:0] raw_o,
  output logic [NUM_CAUSES-1:0] en_o,
  output logic [NUM_CAUSES-1:0] mis_o,
  output logic                  irq_o
);
  logic [NUM_CAUSES-1:0] raw_q, en_q;

  for (genvar i = 0; i < NUM_CAUSES; i++) begin : g_cause
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        raw_q[i] <= 1'b0;
        en_q[i]  <= 1'b0;
      end else begin
        // set has priority over a same-cycle clear
        if (set_i[i])                      raw_q[i] <= 1'b1;
        else if (clr_we_i && wdata_i[i])   raw_q[i] <= 1'b0;
        if (ien_we_i) en_q[i] <= wdata_i[i];
      end
    end
    assign mis_o[i] = raw_q[i] & en_q[i];
  end

  assign raw_o = raw_q;
  assign en_o  = en_q;
  assign irq_o = |mis_o;
endmodule

// File: rtl/fbs_top.sv
module fbs_top
  import fbs_pkg::*;
#(
  parameter int unsigned REG_W      = 32,
  parameter int unsigned ALIGN_BITS = 2,
  parameter int unsigned NUM_CAUSES = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              frame_start_i,
  output logic [REG_W-1:0]  active_base_o,
  output logic              irq_o
);
  logic base_we, ien_we, clr_we, upd_set;
  logic [REG_W-1:0]      pend_base;
  logic [NUM_CAUSES-1:0] set_vec, raw_q, en_q, mis;

  fbs_reg_dec u_dec (
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .base_we_o (base_we),
    .ien_we_o  (ien_we),
    .clr_we_o  (clr_we)
  );

  fbs_base_shadow #(.BASE_W(REG_W), .ALIGN_BITS(ALIGN_BITS)) u_shadow (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (base_we),
    .wdata_i       (reg_wdata_i),
    .frame_start_i (frame_start_i),
    .pend_base_o   (pend_base),
    .act_base_o    (active_base_o),
    .taken_o       (upd_set)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[UPD_BIT] = upd_set;
  end

  fbs_irq_ctrl #(.NUM_CAUSES(NUM_CAUSES)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .ien_we_i (ien_we),
    .clr_we_i (clr_we),
    .wdata_i  (reg_wdata_i[NUM_CAUSES-1:0]),
    .raw_o    (raw_q),
    .en_o     (en_q),
    .mis_o    (mis),
    .irq_o    (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_BASE: reg_rdata_o = pend_base;
      REG_IEN:  reg_rdata_o[NUM_CAUSES-1:0] = en_q;
      REG_RAW:  reg_rdata_o[NUM_CAUSES-1:0] = raw_q;
      REG_MIS:  reg_rdata_o[NUM_CAUSES-1:0] = mis;
      default:  ;
    endcase
  end
endmodule

// File: rtl/fbs_chk.sv
module fbs_chk
  import fbs_pkg::*;
#(
  parameter int unsigned REG_W      = 32,
  parameter int unsigned NUM_CAUSES = 1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  reg_we_i,
  input logic [REG_AW-1:0]     reg_addr_i,
  input logic [REG_W-1:0]      reg_wdata_i,
  input logic                  frame_start_i,
  input logic [REG_W-1:0]      active_base_o,
  input logic                  irq_o,
  input logic                  upd_set,
  input logic [NUM_CAUSES-1:0] raw_q,
  input logic [NUM_CAUSES-1:0] en_q
);
  // R2
  base_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_base_o[1:0] == 2'b00);

  // R3
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(active_base_o));

  // R4
  raw_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw_q[UPD_BIT]) |-> $past(frame_start_i));

  // R8
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_set |=> raw_q[UPD_BIT]);

  // R7
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == REG_CLR && reg_wdata_i[UPD_BIT] && !upd_set)
      |=> !raw_q[UPD_BIT]);

  // R6
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !irq_o);
endmodule

bind fbs_top fbs_chk #(.REG_W(REG_W), .NUM_CAUSES(NUM_CAUSES)) u_fbs_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_we_i      (reg_we_i),
  .reg_addr_i    (reg_addr_i),
  .reg_wdata_i   (reg_wdata_i),
  .frame_start_i (frame_start_i),
  .active_base_o (active_base_o),
  .irq_o         (irq_o),
  .upd_set       (upd_set),
  .raw_q         (raw_q),
  .en_q          (en_q)
);

// File: tb/tb_fbs_top.sv
`timescale 1ns/1ps
module tb_fbs_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fs = 1'b0;
  logic [31:0] act;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic [31:0] m_pend = '0, m_act = '0;
  logic        m_fresh = 1'b0, m_raw = 1'b0, m_en = 1'b0;

  always #2 clk = ~clk;

  fbs_top dut (
    .clk_i (clk), .rst_ni (rst_n), .reg_we_i (we), .reg_addr_i (addr),
    .reg_wdata_i (wdata), .reg_rdata_o (rdata), .frame_start_i (fs),
    .active_base_o (act), .irq_o (irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return m_pend;
      3'd1: return {31'b0, m_en};
      3'd2: return {31'b0, m_raw};
      3'd3: return {31'b0, m_raw & m_en};
      default: return 32'h0;
    endcase
  endfunction

  // one clock with given inputs; model updated from pre-edge state
  task automatic cyc(input logic w, input logic [2:0] a, input logic [31:0] d, input logic f);
    logic set;
    @(negedge clk);
    we = w; addr = a; wdata = d; fs = f;
    @(posedge clk);
    set = f & m_fresh;
    if (f) m_act = m_pend;
    if (w && a == 3'd0) m_fresh = 1'b1;
    else if (f) m_fresh = 1'b0;
    if (w && a == 3'd0) m_pend = d & 32'hFFFF_FFFC;
    if (w && a == 3'd1) m_en = d[0];
    if (set) m_raw = 1'b1;
    else if (w && a == 3'd4 && d[0]) m_raw = 1'b0;
    #1;
  endtask

  task automatic idle();
    cyc(1'b0, 3'd0, 32'h0, 1'b0);
  endtask

  task automatic rd(input string req, input logic [2:0] a);
    @(negedge clk);
    we = 1'b0; fs = 1'b0; addr = a;
    #1;
    chk(req, rdata, exp_read(a));
  endtask

  task automatic out_chk(input string req);
    chk({req, " active"}, act, m_act);
    chk({req, " irq"}, {31'b0, irq}, {31'b0, m_raw & m_en});
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    out_chk("R1");
    for (int a = 0; a < 4; a++) rd("R1 read", 3'(a));

    // R2 alignment
    cyc(1'b1, 3'd0, 32'h1234_5677, 1'b0);
    rd("R2 base read", 3'd0);
    chk("R2 base value", rdata, 32'h1234_5674);

    // R3 not visible before strobe
    idle(); idle();
    out_chk("R3 before strobe");
    chk("R3 still zero", act, 32'h0);
    cyc(1'b0, 3'd0, 32'h0, 1'b1);
    chk("R3 after strobe", act, 32'h1234_5674);
    rd("R4 raw set", 3'd2);
    chk("R4 raw bit", rdata, 32'h1);

    // R7 zero clear does nothing, then clear
    cyc(1'b1, 3'd4, 32'h0, 1'b0);
    rd("R7 zero clear", 3'd2);
    chk("R7 still set", rdata, 32'h1);
    // R6 masking
    rd("R6 mis masked", 3'd3);
    out_chk("R6 en off");
    cyc(1'b1, 3'd1, 32'h1, 1'b0);
    out_chk("R6 en on");
    chk("R6 irq high", {31'b0, irq}, 32'h1);
    rd("R6 mis on", 3'd3);
    cyc(1'b1, 3'd1, 32'h0, 1'b0);
    chk("R6 irq low", {31'b0, irq}, 32'h0);
    cyc(1'b1, 3'd1, 32'h1, 1'b0);
    cyc(1'b1, 3'd4, 32'hFFFF_FFFF, 1'b0);
    rd("R7 cleared", 3'd2);
    chk("R7 raw zero", rdata, 32'h0);
    out_chk("R7");

    // R4 strobe without write
    cyc(1'b0, 3'd0, 32'h0, 1'b1);
    rd("R4 no new write", 3'd2);
    chk("R4 raw stays 0", rdata, 32'h0);
    chk("R4 active same", act, 32'h1234_5674);

    // R9 read-only and unmapped
    cyc(1'b1, 3'd2, 32'h1, 1'b0);
    cyc(1'b1, 3'd3, 32'hFFFF_FFFF, 1'b0);
    rd("R9 raw unchanged", 3'd2);
    chk("R9 raw zero", rdata, 32'h0);
    rd("R9 clr reads 0", 3'd4);
    for (int a = 5; a < 8; a++) rd("R9 unmapped", 3'(a));

    // R5 write and strobe in the same cycle
    cyc(1'b1, 3'd0, 32'hAAAA_0000, 1'b0);
    cyc(1'b1, 3'd0, 32'hBBBB_0003, 1'b1);
    chk("R5 old value taken", act, 32'hAAAA_0000);
    cyc(1'b1, 3'd4, 32'h1, 1'b0);
    cyc(1'b0, 3'd0, 32'h0, 1'b1);
    chk("R5 new value next", act, 32'hBBBB_0000);
    rd("R5 second event", 3'd2);
    chk("R5 raw set", rdata, 32'h1);

    // R8 clear and set together
    cyc(1'b1, 3'd4, 32'h1, 1'b0);
    cyc(1'b1, 3'd0, 32'h0000_1000, 1'b0);
    cyc(1'b1, 3'd4, 32'h1, 1'b1);
    rd("R8 set wins", 3'd2);
    chk("R8 raw set", rdata, 32'h1);
    out_chk("R8");

    // random traffic
    void'($urandom(32'd2024));
    for (int n = 0; n < 4000; n++) begin
      logic        w = ($urandom % 3) == 0;
      logic [2:0]  a = 3'($urandom % 8);
      logic [31:0] d = $urandom;
      logic        f = ($urandom % 5) == 0;
      if (a == 3'd4 || a == 3'd1) d[0] = $urandom % 2;
      cyc(w, a, d, f);
      out_chk("R3 R6 random");
      if ((n % 16) == 0) rd("R2 R9 random read", 3'($urandom % 8));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule